// File: doc/BRIEF.md
# Line-Burst Memory Access Controller

This controller sits between a processor bus port and a word-addressed memory. Each read is carried out as a complete eight-word line burst, whether the access is cacheable or not. Each write is a single word. The processor is held in wait for a fixed number of clocks per operation: twelve for a read and two for a write. The memory side sees the burst start on the line-aligned address and step through the line in ascending order.

On a cacheable read, every word of the line is handed out on a fill channel with a valid strobe and its index within the line, so that a cache can replace the whole line. The requested word also returns to the processor on the last clock of the operation. On a non-cacheable read, the memory still delivers all eight words, but only the requested one reaches the processor and the other seven are dropped. The processor side of the bus uses big-endian byte order. The memory side uses lane order, so the block swaps bytes in both directions.

Top module: `line_burst_ctrl`

## Requirements
- R1: After reset, wait_o, rvalid_o, fill_valid_o, mem_re_o and mem_we_o are all low.
- R2: A read accepted at a clock edge occupies exactly 12 clocks. wait_o is high for the first 11 of them and low on the 12th, where rvalid_o is high and rdata_o carries the requested word.
- R3: A write occupies exactly 2 clocks. wait_o is high on the first clock. On the second clock wait_o is low and mem_we_o is high, with mem_addr_o equal to the request address and mem_wdata_o carrying the write data.
- R4: Every read drives mem_re_o on exactly 8 clocks, whether cacheable_i is high or low. No write drives mem_re_o.
- R5: The burst addresses are the request address with its low 3 bits cleared, followed by the 7 consecutive addresses above it, one per mem_re_o clock in ascending order.
- R6: A cacheable read raises fill_valid_o on 8 consecutive clocks. fill_idx_o steps 0 to 7, and fill_data_o holds the line word at that index. The last strobe falls on the clock where rvalid_o is high.
- R7: A non-cacheable read never raises fill_valid_o, and rdata_o returns only the word at the request address.
- R8: Byte order: bits 8k+7:8k of mem_rdata_i and mem_wdata_o hold the byte at offset k of the word. On rdata_o, wdata_i and fill_data_o, the byte at offset 0 sits in bits 31:24 and the byte at offset 3 in bits 7:0.
- R9: A request raised while an operation is in progress and dropped before that operation's last clock is ignored. It causes no memory access and changes no stored word.
- R10: A request held on the last clock of an operation is accepted at that edge. Back-to-back writes each take their own full 2 clocks, and there is no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| we_i | input | 1 | 1 = write, 0 = read |
| cacheable_i | input | 1 | Read fills a cache line |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data, big-endian |
| wait_o | output | 1 | Processor must hold |
| rdata_o | output | DW | Read word, big-endian |
| rvalid_o | output | 1 | rdata_o valid, read completes |
| fill_valid_o | output | 1 | Line fill word valid |
| fill_idx_o | output | 3 | Word index within the line |
| fill_data_o | output | DW | Line fill word, big-endian |
| mem_addr_o | output | AW | Memory word address |
| mem_re_o | output | 1 | Memory read this clock |
| mem_we_o | output | 1 | Memory write this clock |
| mem_wdata_o | output | DW | Memory write data, lane order |
| mem_rdata_i | input | DW | Memory read data, lane order, same clock |

## Verification
Two events share the last clock of a cacheable read whose address has word index 7. On that clock the final fill strobe, with index 7, coincides with the release of wait_o and the return of the requested word. A bug in the capture register would show up there as a stale word. The bench provokes this by reading the top word of a freshly written line, cacheable. The scoreboard monitor then requires, at that single clock, fill index 7 with the expected line data, rvalid_o high, and rdata_o equal to the word most recently written to that address. A second overlap is the acceptance of a new write on the last clock of the previous one. The bench judges it by counting exactly one wait clock for every write in a back-to-back run.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;
endpackage

// File: rtl/lbc_swap.sv
module lbc_swap #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] in_i,
  output logic [DW-1:0] out_o
);
  localparam int NB = DW / 8;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign out_o[8*b +: 8] = in_i[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
#(
  parameter int RD_LAT = 12,
  parameter int WR_LAT = 2,
  localparam int CNT_W = $clog2(RD_LAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output op_e              op_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  op_e              op_q;
  logic [CNT_W-1:0] end_cnt;

  assign end_cnt  = (op_q == OP_WR) ? CNT_W'(WR_LAT - 1) : CNT_W'(RD_LAT - 1);
  assign last_o   = busy_q && (cnt_q == end_cnt);
  assign accept_o = req_i && (!busy_q || last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_RD;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      op_q   <= we_i ? OP_WR : OP_RD;
    end else if (last_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/lbc_fill.sv
module lbc_fill #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LINE_W  = 8,
  parameter int RD_LAT  = 12,
  localparam int IDX_W  = $clog2(LINE_W),
  localparam int CNT_W  = $clog2(RD_LAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             cacheable_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    word_i,
  output logic             mem_re_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             fill_valid_o,
  output logic [IDX_W-1:0] fill_idx_o,
  output logic [DW-1:0]    fill_data_o,
  output logic [DW-1:0]    rdata_o
);
  // fetch window ends one clock before the final clock; one register stage follows
  localparam int FETCH0 = RD_LAT - LINE_W - 1;

  logic             fetch;
  logic [CNT_W-1:0] rel;
  logic [IDX_W-1:0] widx;
  logic             fv_q;
  logic [IDX_W-1:0] fidx_q;
  logic [DW-1:0]    fdata_q;
  logic [DW-1:0]    rdata_q;

  assign rel   = cnt_i - CNT_W'(FETCH0);
  assign fetch = rd_i && (cnt_i >= CNT_W'(FETCH0)) && (cnt_i < CNT_W'(FETCH0 + LINE_W));
  assign widx  = rel[IDX_W-1:0];

  assign mem_re_o   = fetch;
  assign mem_addr_o = {addr_i[AW-1:IDX_W], widx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_q    <= 1'b0;
      fidx_q  <= '0;
      fdata_q <= '0;
      rdata_q <= '0;
    end else begin
      fv_q <= fetch && cacheable_i;
      if (fetch) begin
        fidx_q  <= widx;
        fdata_q <= word_i;
        if (widx == addr_i[IDX_W-1:0]) rdata_q <= word_i;
      end
    end
  end

  assign fill_valid_o = fv_q;
  assign fill_idx_o   = fidx_q;
  assign fill_data_o  = fdata_q;
  assign rdata_o      = rdata_q;
endmodule

// File: rtl/line_burst_ctrl.sv
module line_burst_ctrl
  import lbc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int LINE_W = 8,
  parameter int RD_LAT = 12,
  parameter int WR_LAT = 2,
  localparam int IDX_W = $clog2(LINE_W),
  localparam int CNT_W = $clog2(RD_LAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             cacheable_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             wait_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             fill_valid_o,
  output logic [IDX_W-1:0] fill_idx_o,
  output logic [DW-1:0]    fill_data_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i
);
  logic             accept, busy, last;
  op_e              op;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic             cach_q;
  logic [DW-1:0]    rd_word;
  logic             re;
  logic [AW-1:0]    raddr;

  lbc_seq #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i,
    .accept_o(accept), .busy_o(busy), .last_o(last), .op_o(op), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      cach_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      cach_q  <= cacheable_i;
    end
  end

  lbc_swap #(.DW(DW)) u_rd_swap (.in_i(mem_rdata_i), .out_o(rd_word));
  lbc_swap #(.DW(DW)) u_wr_swap (.in_i(wdata_q),     .out_o(mem_wdata_o));

  lbc_fill #(.AW(AW), .DW(DW), .LINE_W(LINE_W), .RD_LAT(RD_LAT)) u_fill (
    .clk_i, .rst_ni,
    .rd_i(busy && op == OP_RD), .cacheable_i(cach_q), .cnt_i(cnt),
    .addr_i(addr_q), .word_i(rd_word),
    .mem_re_o(re), .mem_addr_o(raddr),
    .fill_valid_o, .fill_idx_o, .fill_data_o, .rdata_o
  );

  assign wait_o     = busy && !last;
  assign rvalid_o   = last && op == OP_RD;
  assign mem_we_o   = last && op == OP_WR;
  assign mem_re_o   = re;
  assign mem_addr_o = re ? raddr : addr_q;
endmodule

// File: rtl/line_burst_ctrl_chk.sv
module line_burst_ctrl_chk #(
  parameter int AW    = 16,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wait_o,
  input logic             rvalid_o,
  input logic             fill_valid_o,
  input logic [IDX_W-1:0] fill_idx_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_re_o,
  input logic             mem_we_o
);
  AST_RVALID_RELEASES_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !wait_o); // R2
  AST_WRITE_AFTER_ONE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(wait_o) && !wait_o); // R3
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rvalid_o && mem_we_o)); // R3
  AST_FETCH_UNDER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> wait_o && !mem_we_o); // R4
  AST_BURST_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o && $past(mem_re_o) |-> mem_addr_o == $past(mem_addr_o) + 1'b1); // R5
  AST_FILL_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o && fill_idx_o != '0 |-> $past(fill_valid_o) && fill_idx_o == $past(fill_idx_o) + 1'b1); // R6
  AST_FILL_NOT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> !mem_we_o); // R6
endmodule

bind line_burst_ctrl line_burst_ctrl_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .wait_o, .rvalid_o, .fill_valid_o, .fill_idx_o,
  .mem_addr_o, .mem_re_o, .mem_we_o
);

// File: tb/line_burst_ctrl_bench.sv
module line_burst_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, cacheable_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic wait_o, rvalid_o, fill_valid_o, mem_re_o, mem_we_o;
  logic [DW-1:0] rdata_o, fill_data_o, mem_wdata_o, mem_rdata_i;
  logic [2:0] fill_idx_o;
  logic [AW-1:0] mem_addr_o;

  always #5 clk_i = ~clk_i;

  line_burst_ctrl u_line_burst_ctrl (.*);

  logic [31:0] mem [256];   // lane order, written by the design
  logic [31:0] ref_w [256]; // processor view, written by the bench
  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  always @(posedge clk_i) if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;

  function automatic logic [31:0] lanes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  typedef struct { bit rd; bit cach; logic [AW-1:0] addr; logic [31:0] data; } item_t;
  item_t exp_q[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic op(input bit rd, input bit cach, input logic [AW-1:0] a, input logic [31:0] d);
    item_t it;
    @(negedge clk_i);
    while (wait_o) @(negedge clk_i);
    if (!rd) ref_w[a[7:0]] = d;
    it.rd = rd; it.cach = cach; it.addr = a; it.data = rd ? ref_w[a[7:0]] : d;
    exp_q.push_back(it);
    req_i = 1'b1; we_i = !rd; cacheable_i = cach; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 req_i = 1'b0;
  endtask

  // monitor
  int run = 0, re_cnt = 0, fill_cnt = 0;
  always @(negedge clk_i) if (rst_ni && !done) begin
    item_t h;
    bit have;
    have = exp_q.size() > 0;
    if (have) h = exp_q[0];
    if (mem_re_o)
      chk(have && h.rd && mem_addr_o == {h.addr[AW-1:3], 3'(re_cnt)}, "R5 burst addr",
          32'(mem_addr_o), 32'({h.addr[AW-1:3], 3'(re_cnt)}));
    if (mem_re_o) re_cnt++;
    if (fill_valid_o) begin
      chk(have && h.cach && fill_idx_o == 3'(fill_cnt), "R6 fill idx", 32'(fill_idx_o), fill_cnt);
      chk(fill_data_o == ref_w[{h.addr[7:3], 3'(fill_cnt)}], "R6/R8 fill data",
          fill_data_o, ref_w[{h.addr[7:3], 3'(fill_cnt)}]);
      fill_cnt++;
    end
    if (wait_o) run++;
    else if (run > 0) begin
      void'(exp_q.pop_front());
      if (h.rd) begin
        chk(rvalid_o && !mem_we_o, "R2 read done strobe", 32'(rvalid_o), 1);
        chk(run == 11, "R2 read wait clocks", run, 11);
        chk(rdata_o == h.data, h.cach ? "R2/R8 cached read data" : "R7/R8 uncached read data", rdata_o, h.data);
        chk(re_cnt == 8, "R4 burst length", re_cnt, 8);
        chk(fill_cnt == (h.cach ? 8 : 0), h.cach ? "R6 fill count" : "R7 no fill", fill_cnt, h.cach ? 8 : 0);
      end else begin
        chk(mem_we_o && !rvalid_o, "R3 write strobe", 32'(mem_we_o), 1);
        chk(run == 1, "R3/R10 write wait clocks", run, 1);
        chk(mem_addr_o == h.addr, "R3 write addr", 32'(mem_addr_o), 32'(h.addr));
        chk(mem_wdata_o == lanes(h.data), "R8 write lanes", mem_wdata_o, lanes(h.data));
        chk(re_cnt == 0, "R4 no fetch on write", re_cnt, 0);
      end
      run = 0; re_cnt = 0; fill_cnt = 0;
    end else if (rvalid_o || mem_we_o)
      chk(0, "R9 stray completion", 32'({rvalid_o, mem_we_o}), 0);
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = (32'(i) * 32'h01030507) ^ 32'hA5000000;
      ref_w[i] = lanes(mem[i]);
    end
    repeat (3) @(negedge clk_i);
    chk(!wait_o && !rvalid_o && !fill_valid_o && !mem_re_o && !mem_we_o, "R1 reset outputs",
        32'({wait_o, rvalid_o, fill_valid_o, mem_re_o, mem_we_o}), 0);
    rst_ni = 1'b1;
    // R10 back-to-back writes filling one line
    for (int i = 0; i < 8; i++) op(0, 0, 16'h0010 + 16'(i), 32'h11223300 + 32'(i * 17));
    op(1, 1, 16'h0017, 0);   // R6 last fill coincides with word return
    op(1, 1, 16'h0010, 0);
    op(1, 0, 16'h0013, 0);   // R7
    op(1, 0, 16'h0025, 0);
    op(1, 1, 16'h002A, 0);
    // R9 request during a burst, dropped before the last clock
    op(1, 0, 16'h0031, 0);
    repeat (3) @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 16'h0010; wdata_i = 32'hDEADBEEF;
    @(negedge clk_i);
    req_i = 1'b0;
    op(1, 0, 16'h0010, 0);   // R9 stored word unchanged
    op(0, 1, 16'h0044, 32'h0A0B0C0D);
    op(0, 0, 16'h0045, 32'hF0E0D0C0);
    op(1, 1, 16'h0045, 0);
    for (int i = 0; i < 50 && exp_q.size() > 0; i++) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all operations completed", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule